// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces a signed frequency-offset code that a PLL feedback divider adds to its nominal ratio, so that the output frequency sweeps slowly and the emitted energy spreads over a band. The offset is advanced only on a reference-clock tick. After a programmable number of ticks it moves by one step: up by an unsigned rise amount, down by an amount given in two's complement. The step repeats until the offset meets the bound of the selected spread kind.

Two profile shapes are offered. The pendulum shape walks the offset down to the lower bound, turns it round and walks it up to the upper bound, and repeats. The plain shape ramps down only and jumps back to the upper bound once it has reached the lower one. Kind, shape and step sizes are held in an active copy that takes new input values only at a zero crossing of the offset, or at any time while spreading is off. A reprogramming therefore never cuts a sweep short in mid-band.

Top module: `ssg_profile_gen`

## Requirements
- R1: After reset `offset` is 0 and `dir_up` is 0.
- R2: While `ss_en` is 0, `offset` and `dir_up` are 0 from the next clock edge on, ticks have no effect, and the tick count toward the next step restarts from zero.
- R3: With spreading on, a step is taken on every Nth tick, where N is `dwell_code` and a code of 0 counts as 1. Ticks in between and cycles without a tick leave `offset` unchanged.
- R4: An upward step adds `rise_step`, read as unsigned (0 to 15).
- R5: A downward step subtracts (16 − `fall_step`) mod 16, so that 1111 means 1, 1110 means 2, 1001 means 7, 1000 means 8 and 0000 means 0.
- R6: `spread_kind` sets the bounds [lo, hi] with SPAN = 64: 00 gives [−SPAN, 0], 01 gives [−SPAN/2, 0], 10 gives [−SPAN/2, +SPAN/2] and 11 gives [−SPAN/4, +SPAN/4].
- R7: With `pendulum` = 1, the offset starts downward from zero. A downward step that would reach or pass lo stops at lo and sets `dir_up`. An upward step that would reach or pass hi stops at hi and clears `dir_up`.
- R8: With `pendulum` = 0, each step moves down and stops at lo. The step after lo has been reached loads hi. `dir_up` is 0 after every such step.
- R9: While spreading is on, changes to `spread_kind`, `pendulum`, `rise_step` and `fall_step` take effect only after a step whose result is zero or has the opposite sign to the previous offset. `dwell_code` acts at once.
- R10: `offset` never leaves the range [−SPAN, +SPAN].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle reference tick |
| ss_en | input | 1 | Spreading on (1) or offset held at zero (0) |
| spread_kind | input | 2 | Bound selection (R6) |
| pendulum | input | 1 | 1 selects the triangle shape, 0 selects the falling ramp with wrap |
| rise_step | input | STEP_W | Unsigned upward step |
| fall_step | input | STEP_W | Downward step in two's complement |
| dwell_code | input | DWELL_W | Ticks per step |
| offset | output | OFF_W | Signed frequency-offset code |
| dir_up | output | 1 | 1 while the pendulum is ascending |

## Verification
A dwell counter that slips shows at the ports on the very next tick, as a step that comes one tick early or late. A direction bit that is wrong shows within one step, because the offset moves away from a bound it should have turned at. A stale or early copy of the active configuration stays hidden until the first step after the next zero crossing. It then shows as the wrong step size or the wrong clamp value, so the bench reprograms the block in mid-sweep and keeps ticking through that crossing. Disabling is checked one edge after `ss_en` falls, both for the zero output and for the restart of the dwell count.

// File: rtl/ssg_pkg.sv
`timescale 1ns/1ps
package ssg_pkg;

  typedef enum logic [1:0] {
    SPR_DOWN_FULL = 2'b00,
    SPR_DOWN_HALF = 2'b01,
    SPR_CTR_HALF  = 2'b10,
    SPR_CTR_QTR   = 2'b11
  } spread_kind_e;

  // lowest offset a kind may reach
  function automatic int kind_floor(spread_kind_e k, int span);
    case (k)
      SPR_DOWN_FULL: return -span;
      SPR_CTR_QTR:   return -(span / 4);
      default:       return -(span / 2);
    endcase
  endfunction

  // highest offset a kind may reach
  function automatic int kind_ceil(spread_kind_e k, int span);
    case (k)
      SPR_CTR_HALF: return span / 2;
      SPR_CTR_QTR:  return span / 4;
      default:      return 0;
    endcase
  endfunction

  // ticks per step; a zero code behaves as one
  function automatic int dwell_limit(int code);
    return (code == 0) ? 1 : code;
  endfunction

endpackage

// File: rtl/ssg_dwell.sv
`timescale 1ns/1ps
module ssg_dwell #(
  parameter int DWELL_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               tick,
  input  logic [DWELL_W-1:0] code,
  output logic               step_go
);
  logic [DWELL_W-1:0] cnt;
  logic [DWELL_W:0]   cnt_nx;
  logic [DWELL_W:0]   lim;

  assign cnt_nx  = {1'b0, cnt} + (DWELL_W+1)'(1);
  assign lim     = (DWELL_W+1)'(ssg_pkg::dwell_limit(int'(code)));
  assign step_go = tick && !clr && (cnt_nx >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= step_go ? '0 : DWELL_W'(cnt_nx);
  end
endmodule

// File: rtl/ssg_cfg.sv
`timescale 1ns/1ps
module ssg_cfg #(
  parameter int STEP_W = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [1:0]            kind_in,
  input  logic                  pend_in,
  input  logic [STEP_W-1:0]     rise_in,
  input  logic [STEP_W-1:0]     fall_in,
  output ssg_pkg::spread_kind_e kind,
  output logic                  pend,
  output logic [STEP_W-1:0]     rise,
  output logic [STEP_W-1:0]     fall_mag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind     <= ssg_pkg::SPR_DOWN_HALF;
      pend     <= 1'b1;
      rise     <= '0;
      fall_mag <= STEP_W'(2);
    end else if (load) begin
      kind     <= ssg_pkg::spread_kind_e'(kind_in);
      pend     <= pend_in;
      rise     <= rise_in;
      fall_mag <= '0 - fall_in;   // negate the two's-complement code
    end
  end
endmodule

// File: rtl/ssg_walk.sv
`timescale 1ns/1ps
module ssg_walk #(
  parameter int OFF_W  = 8,
  parameter int SPAN   = 64,
  parameter int STEP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     go,
  input  ssg_pkg::spread_kind_e    kind,
  input  logic                     pend,
  input  logic [STEP_W-1:0]        rise,
  input  logic [STEP_W-1:0]        fall_mag,
  output logic signed [OFF_W-1:0]  offset,
  output logic                     dir_up,
  output logic                     crossed,
  output logic signed [OFF_W-1:0]  floor_b
);
  localparam int EW = OFF_W + 2;

  logic signed [EW-1:0] lo, hi, cur, up_sum, dn_diff, nxt;
  logic                 nd;

  assign lo      = EW'(ssg_pkg::kind_floor(kind, SPAN));
  assign hi      = EW'(ssg_pkg::kind_ceil(kind, SPAN));
  assign floor_b = OFF_W'(ssg_pkg::kind_floor(kind, SPAN));
  assign cur     = EW'(offset);
  assign up_sum  = cur + $signed(EW'(rise));
  assign dn_diff = cur - $signed(EW'(fall_mag));

  always_comb begin
    nxt = cur;
    nd  = 1'b0;
    if (pend) begin
      if (dir_up) begin
        if (up_sum >= hi) begin nxt = hi; nd = 1'b0; end
        else              begin nxt = up_sum; nd = 1'b1; end
      end else begin
        if (dn_diff <= lo) begin nxt = lo; nd = 1'b1; end
        else               begin nxt = dn_diff; nd = 1'b0; end
      end
    end else begin
      if (cur <= lo)         nxt = hi;
      else if (dn_diff < lo) nxt = lo;
      else                   nxt = dn_diff;
    end
  end

  assign crossed = go && ((nxt == '0) || (nxt[EW-1] != cur[EW-1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
      dir_up <= 1'b0;
    end else if (!en) begin
      offset <= '0;
      dir_up <= 1'b0;
    end else if (go) begin
      offset <= OFF_W'(nxt);
      dir_up <= nd;
    end
  end
endmodule

// File: rtl/ssg_profile_gen.sv
`timescale 1ns/1ps
module ssg_profile_gen #(
  parameter int OFF_W   = 8,
  parameter int SPAN    = 64,
  parameter int STEP_W  = 4,
  parameter int DWELL_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic                     ss_en,
  input  logic [1:0]               spread_kind,
  input  logic                     pendulum,
  input  logic [STEP_W-1:0]        rise_step,
  input  logic [STEP_W-1:0]        fall_step,
  input  logic [DWELL_W-1:0]       dwell_code,
  output logic signed [OFF_W-1:0]  offset,
  output logic                     dir_up
);
  // named internal events, visible to the bound checker
  logic                    step_go;
  logic                    zero_cross;
  logic                    cfg_load;
  ssg_pkg::spread_kind_e   act_kind;
  logic                    act_pend;
  logic [STEP_W-1:0]       act_rise;
  logic [STEP_W-1:0]       act_fall_mag;
  logic signed [OFF_W-1:0] floor_b;

  assign cfg_load = !ss_en || zero_cross;

  ssg_dwell #(.DWELL_W(DWELL_W)) u_dwell (
    .clk(clk), .rst_n(rst_n), .clr(!ss_en), .tick(tick),
    .code(dwell_code), .step_go(step_go)
  );

  ssg_cfg #(.STEP_W(STEP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .kind_in(spread_kind), .pend_in(pendulum),
    .rise_in(rise_step), .fall_in(fall_step),
    .kind(act_kind), .pend(act_pend), .rise(act_rise), .fall_mag(act_fall_mag)
  );

  ssg_walk #(.OFF_W(OFF_W), .SPAN(SPAN), .STEP_W(STEP_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .en(ss_en), .go(step_go),
    .kind(act_kind), .pend(act_pend), .rise(act_rise), .fall_mag(act_fall_mag),
    .offset(offset), .dir_up(dir_up), .crossed(zero_cross), .floor_b(floor_b)
  );
endmodule

// File: rtl/ssg_profile_chk.sv
`timescale 1ns/1ps
module ssg_profile_chk #(
  parameter int OFF_W = 8,
  parameter int SPAN  = 64
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ss_en,
  input logic                    step_go,
  input logic                    cfg_load,
  input logic                    act_pend,
  input logic [1:0]              act_kind,
  input logic signed [OFF_W-1:0] offset,
  input logic signed [OFF_W-1:0] floor_b,
  input logic                    dir_up
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_en |=> (offset == '0) && !dir_up); // R2

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_en && !step_go) |=> $stable(offset)); // R3

  AST_TURN_AT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_up) |-> (offset == floor_b)); // R7

  AST_RAMP_DIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !act_pend) |=> !dir_up); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(act_kind) && $stable(act_pend)); // R9

  AST_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(offset) >= -SPAN) && (int'(offset) <= SPAN)); // R10
endmodule

bind ssg_profile_gen ssg_profile_chk #(.OFF_W(OFF_W), .SPAN(SPAN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ss_en(ss_en), .step_go(step_go),
  .cfg_load(cfg_load), .act_pend(act_pend), .act_kind(act_kind),
  .offset(offset), .floor_b(floor_b), .dir_up(dir_up)
);

// File: tb/sim_ssg_profile_gen.sv
`timescale 1ns/1ps
module sim_ssg_profile_gen;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic              ss_en = 1'b0;
  logic [1:0]        spread_kind = 2'b01;
  logic              pendulum = 1'b1;
  logic [3:0]        rise_step = 4'd0;
  logic [3:0]        fall_step = 4'b1110;
  logic [5:0]        dwell_code = 6'h10;
  logic signed [7:0] offset;
  logic              dir_up;

  always #10 clk = ~clk;   // 50 MHz

  ssg_profile_gen u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ss_en(ss_en),
    .spread_kind(spread_kind), .pendulum(pendulum),
    .rise_step(rise_step), .fall_step(fall_step), .dwell_code(dwell_code),
    .offset(offset), .dir_up(dir_up)
  );

  typedef struct { int off; bit dir; string tag; } exp_t;
  exp_t exp_q[$];

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;

  // reference state, derived from the requirements
  int m_off = 0, m_cnt = 0, m_kind = 1, m_rise = 0, m_fall = 2;
  bit m_dir = 0, m_pend = 1;

  task automatic compare(string tag, int a_off, bit a_dir, int e_off, bit e_dir);
    n_cmp++;
    if (a_off != e_off || a_dir != e_dir) begin
      n_bad++;
      $display("FAIL %s: offset=%0d dir_up=%0b expected offset=%0d dir_up=%0b",
               tag, a_off, a_dir, e_off, e_dir);
    end
  endtask

  task automatic model_latch();
    m_kind = int'(spread_kind);
    m_pend = pendulum;
    m_rise = int'(rise_step);
    m_fall = (16 - int'(fall_step)) % 16;   // R5 magnitude
  endtask

  task automatic model_step();
    int lo, hi, prev, nxt;
    bit nd;
    lo = (m_kind == 0) ? -64 : ((m_kind == 3) ? -16 : -32);   // R6
    hi = (m_kind == 2) ? 32  : ((m_kind == 3) ? 16  : 0);
    prev = m_off;
    nd = 0;
    if (m_pend) begin
      if (m_dir) begin
        nxt = prev + m_rise;
        if (nxt >= hi) nxt = hi; else nd = 1;
      end else begin
        nxt = prev - m_fall;
        if (nxt <= lo) begin nxt = lo; nd = 1; end
      end
    end else begin
      if (prev <= lo) nxt = hi;
      else begin
        nxt = prev - m_fall;
        if (nxt < lo) nxt = lo;
      end
    end
    m_off = nxt;
    m_dir = nd;
    if (nxt == 0 || ((nxt < 0) != (prev < 0))) model_latch();   // R9
  endtask

  task automatic set_cfg(logic [1:0] k, bit p, logic [3:0] r, logic [3:0] f, logic [5:0] d);
    @(negedge clk);
    spread_kind = k; pendulum = p; rise_step = r; fall_step = f; dwell_code = d;
    if (!ss_en) model_latch();
  endtask

  task automatic enable();
    @(negedge clk);
    ss_en = 1'b1;
  endtask

  // driver: one tick per call, expected result queued before the edge
  task automatic ticks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      @(negedge clk);
      tick = 1'b1;
      if (ss_en) begin
        int lim;
        lim = (dwell_code == 0) ? 1 : int'(dwell_code);
        if (m_cnt + 1 >= lim) begin m_cnt = 0; model_step(); end
        else m_cnt++;
      end
      e.off = m_off; e.dir = m_dir; e.tag = tag;
      exp_q.push_back(e);
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  // R2: disabling clears the output on the next edge and ignores ticks
  task automatic disable_run();
    @(negedge clk);
    ss_en = 1'b0;
    m_off = 0; m_dir = 0; m_cnt = 0;
    model_latch();
    @(posedge clk);
    #5;
    compare("R2 disable", int'(offset), dir_up, 0, 1'b0);
    ticks(2, "R2 ignored tick");
  endtask

  // monitor: pops one expectation per tick, samples after the edge
  initial begin
    forever begin
      @(posedge clk);
      if (tick) begin
        #5;
        if (exp_q.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL scoreboard: offset=%0d with no expected item", int'(offset));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          compare(e.tag, int'(offset), dir_up, e.off, e.dir);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset", int'(offset), dir_up, 0, 1'b0);

    // R7/R6: pendulum, kind 01, rise 3, fall 2, step per tick
    set_cfg(2'b01, 1'b1, 4'd3, 4'b1110, 6'd1);
    enable();
    ticks(40, "R7");
    // R9: switch to kind 11 in mid-sweep; applies after next crossing
    set_cfg(2'b11, 1'b1, 4'd3, 4'b1110, 6'd1);
    ticks(30, "R9");

    // R8: falling ramp with wrap, kind 00, fall 8
    disable_run();
    set_cfg(2'b00, 1'b0, 4'd0, 4'b1000, 6'd1);
    enable();
    ticks(20, "R8");

    // R3: three ticks per step, then R5/R4 with fall 1 and rise 15
    disable_run();
    set_cfg(2'b10, 1'b1, 4'd15, 4'b1111, 6'd3);
    enable();
    ticks(60, "R3");
    set_cfg(2'b10, 1'b1, 4'd15, 4'b1111, 6'd1);
    ticks(40, "R5");
    ticks(20, "R4");
    // R3: dwell code 0 behaves as 1
    set_cfg(2'b10, 1'b1, 4'd15, 4'b1111, 6'd0);
    ticks(10, "R3 code0");

    // R5: fall code 0000 gives no movement; new code lands at the zero step
    disable_run();
    set_cfg(2'b10, 1'b1, 4'd5, 4'b0000, 6'd1);
    enable();
    ticks(5, "R5 zero step");
    set_cfg(2'b10, 1'b1, 4'd5, 4'b1001, 6'd1);
    ticks(20, "R9 reload");

    // R6/R10: kind 00 pendulum reaches the full span
    disable_run();
    set_cfg(2'b00, 1'b1, 4'd15, 4'b1000, 6'd2);
    enable();
    ticks(40, "R6");
    ticks(40, "R10");

    // R8: center kind, wrap crosses zero
    disable_run();
    set_cfg(2'b10, 1'b0, 4'd0, 4'b1001, 6'd1);
    enable();
    ticks(30, "R8 center");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule